// File: doc/BRIEF.md
# Byte-Wide nvRAM Command Loader

This block sits behind a 32-bit host control register and turns byte-wide writes into a staged access to an external non-volatile memory. The top byte lane carries a 3-bit command field in bits 31:29. Three of its codes arm one of three holding registers: the low address byte, the high address byte, or the write-data byte. The arming persists. Every later write on the bits 23:16 lane lands in whichever register is armed, until another command arrives.

A fourth code launches the transfer. It disarms all loading, raises a busy flag and sends a one-cycle start pulse to the memory interface controller. That controller signals completion and success or failure back to the block. The assembled 11-bit address, the data byte, busy, the failure flag and the arming state can all be read back through a status word.

The serial memory protocol and any arbitration between host ports are handled elsewhere. Software is expected to poll busy before it issues a start.

Top module: `nvcmd_seq`

## Requirements
- R1: After a synchronous active-low reset, no register is armed. The low address, high address and write-data registers are zero, and busy, fail and the start pulse are all low.
- R2: A command write with code 3'b100 arms the low-address register. A later data write puts the data lane byte into address bits 7:0.
- R3: Code 3'b101 arms the high-address register. From a data byte, only the low 3 bits are kept, and they form address bits 10:8 of the 11-bit address.
- R4: Code 3'b000 arms the write-data register. A later data byte appears on `mem_wdata`.
- R5: At most one register is armed at any time. Arming one register disarms the other two.
- R6: While a register stays armed, each further data write overwrites it. A data write while nothing is armed changes no register.
- R7: Code 3'b110 while not busy does four things: it disarms every register, sets busy, clears fail, and gives a start pulse that is high for exactly the one cycle after the write.
- R8: Code 3'b110 while busy is ignored. There is no start pulse, and the arming state and fail stay unchanged.
- R9: Command codes 3'b001, 3'b010, 3'b011 and 3'b111 change no arming state and no register.
- R10: `ctl_done` while busy clears busy and stores `ctl_fail` as the fail flag. Fail then holds until the next accepted start. `ctl_done` while not busy has no effect.
- R11: The `rd_data` layout is as follows. Bit 31 is busy and bit 28 is fail. Bits 26:24 are the arming state, one-hot: bit 24 is low, bit 25 is high and bit 26 is write-data. Bits 23:16 hold the armed register's contents, or zero when nothing is armed. Bits 10:0 hold the address. All other bits read zero.
- R12: A write that enables both the command lane and the data lane first loads the data byte into the register armed before the write. The command then takes effect.
- R13: A command is taken only when byte enable 3 is set, and a data byte only when byte enable 2 is set. Writes on other lanes change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Host write strobe for the control register |
| wr_data | input | 32 | Host write data |
| byte_en | input | 4 | Byte lane enables, bit n covers bits 8n+7:8n |
| ctl_done | input | 1 | Memory controller reports the transfer finished |
| ctl_fail | input | 1 | With `ctl_done`: the transfer was not acknowledged |
| rd_data | output | 32 | Status and register readback word |
| busy | output | 1 | A transfer is in flight |
| start_pulse | output | 1 | One-cycle request to the memory controller |
| mem_addr | output | 11 | Assembled memory address |
| mem_wdata | output | 8 | Byte to be written to memory |

## Verification
The bench first walks the documented order: arm low, write data, arm high, write data, arm write-data, write data, start. This shows that each code routes the byte to the correct register and that high-address bits above bit 2 are dropped.

Repeated data writes under one arming show the sticky behaviour. Data written with nothing armed, unassigned codes and writes on other lanes show that those inputs are ignored. Writes with both lanes enabled settle whether the data or the command is handled first.

Starts while busy separate accepted starts from ignored ones. Completion with and without failure shows how fail is stored and how it is cleared. A long stretch of pseudo-random writes and completions, checked each cycle against a behavioural model, covers the interleavings the directed steps miss.

// File: rtl/nvcmd_pkg.sv
// Package: shared command codes, arming indices and decoded-event type.
// Assumes the command field is three bits wide.
package nvcmd_pkg;

    localparam int CMD_W = 3;

    typedef enum logic [CMD_W-1:0] {
        CMD_ARM_WDATA = 3'b000,
        CMD_ARM_LOW   = 3'b100,
        CMD_ARM_HIGH  = 3'b101,
        CMD_START     = 3'b110
    } cmd_code_e;

    localparam int ARM_N    = 3;
    localparam int ARM_LOW  = 0;
    localparam int ARM_HIGH = 1;
    localparam int ARM_WD   = 2;

    typedef struct packed {
        logic set_low;
        logic set_high;
        logic set_wd;
        logic start_req;
        logic unknown;
    } cmd_ev_t;

endpackage

// File: rtl/nvcmd_decode.sv
// Module: nvcmd_decode
// Splits one host write into a command event (from the command lane) and
// a data event (from the data lane). Purely combinational.
// Assumes the command field and the data byte each sit inside one lane.
module nvcmd_decode
    import nvcmd_pkg::*;
#(
    parameter int REG_W    = 32,
    parameter int BYTE_W   = 8,
    parameter int CMD_MSB  = 31,
    parameter int DATA_LSB = 16
) (
    input  logic                    wr_en,
    input  logic [REG_W-1:0]        wr_data,
    input  logic [REG_W/BYTE_W-1:0] byte_en,
    output cmd_ev_t                 ev,
    output logic                    data_valid,
    output logic [BYTE_W-1:0]       data_byte
);

    localparam int CMD_LSB   = CMD_MSB - CMD_W + 1;
    localparam int CMD_LANE  = CMD_MSB / BYTE_W;
    localparam int DATA_LANE = DATA_LSB / BYTE_W;

    logic             cmd_valid;
    logic [CMD_W-1:0] code;
    logic             unused_bits;

    assign cmd_valid   = wr_en && byte_en[CMD_LANE];
    assign code        = wr_data[CMD_MSB:CMD_LSB];
    assign data_valid  = wr_en && byte_en[DATA_LANE];
    assign data_byte   = wr_data[DATA_LSB +: BYTE_W];
    assign unused_bits = ^{wr_data, byte_en};

    // Map the command code to a single decoded event.
    always_comb begin
        ev = '0;
        if (cmd_valid) begin
            case (code)
                CMD_ARM_LOW:   ev.set_low   = 1'b1;
                CMD_ARM_HIGH:  ev.set_high  = 1'b1;
                CMD_ARM_WDATA: ev.set_wd    = 1'b1;
                CMD_START:     ev.start_req = 1'b1;
                default:       ev.unknown   = 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/nvcmd_arm.sv
// Module: nvcmd_arm
// Holds the one-hot load-enable state that picks the register armed for
// data writes. An accepted start disarms everything; a start ignored while
// busy leaves the state alone.
// Assumes the decoder raises at most one event per cycle.
module nvcmd_arm
    import nvcmd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  cmd_ev_t          ev,
    input  logic             start_accept,
    output logic [ARM_N-1:0] arm
);

    logic [ARM_N-1:0] arm_nxt;

    // Choose the next arming state from the current command event.
    always_comb begin
        arm_nxt = arm;
        if (start_accept) begin
            arm_nxt = '0;
        end else if (ev.set_low) begin
            arm_nxt = ARM_N'(1) << ARM_LOW;
        end else if (ev.set_high) begin
            arm_nxt = ARM_N'(1) << ARM_HIGH;
        end else if (ev.set_wd) begin
            arm_nxt = ARM_N'(1) << ARM_WD;
        end
    end

    // Register the arming state, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) arm <= '0;
        else        arm <= arm_nxt;
    end

    p_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(arm));

    p_unknown_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ev.unknown |=> $stable(arm));

    p_start_disarm_r7: assert property (@(posedge clk) disable iff (!rst_n)
        start_accept |=> (arm == '0));

endmodule

// File: rtl/nvcmd_hold.sv
// Module: nvcmd_hold
// The three holding registers. A data byte loads whichever register was
// armed before this cycle's command takes effect. Only the low
// ADDR_W-BYTE_W bits of a high-address byte are kept.
// Assumes ADDR_W lies between BYTE_W+1 and 2*BYTE_W.
module nvcmd_hold
    import nvcmd_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              data_valid,
    input  logic [BYTE_W-1:0] data_byte,
    input  logic [ARM_N-1:0]  arm,
    output logic [ADDR_W-1:0] addr,
    output logic [BYTE_W-1:0] wdata
);

    localparam int HI_W = ADDR_W - BYTE_W;

    logic [BYTE_W-1:0] lo_q;
    logic [HI_W-1:0]   hi_q;
    logic              ld_any;

    assign ld_any = data_valid && (arm != '0);
    assign addr   = {hi_q, lo_q};

    // Low address byte: loads while the low register is armed.
    always_ff @(posedge clk) begin
        if (!rst_n)                          lo_q <= '0;
        else if (data_valid && arm[ARM_LOW]) lo_q <= data_byte;
    end

    // High address bits: keep only the bits that fit the address width.
    always_ff @(posedge clk) begin
        if (!rst_n)                           hi_q <= '0;
        else if (data_valid && arm[ARM_HIGH]) hi_q <= data_byte[HI_W-1:0];
    end

    // Write-data byte: loads while the write-data register is armed.
    always_ff @(posedge clk) begin
        if (!rst_n)                         wdata <= '0;
        else if (data_valid && arm[ARM_WD]) wdata <= data_byte;
    end

    p_idle_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_any |=> $stable(addr));

    p_idle_wdata_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_any |=> $stable(wdata));

endmodule

// File: rtl/nvcmd_xfer.sv
// Module: nvcmd_xfer
// Transfer handshake toward the memory controller. Owns busy, the fail
// flag and the one-cycle start pulse. Starts are accepted only while idle,
// and completion only while busy.
// Assumes ctl_done is a single-cycle strobe.
module nvcmd_xfer (
    input  logic clk,
    input  logic rst_n,
    input  logic start_req,
    input  logic ctl_done,
    input  logic ctl_fail,
    output logic start_accept,
    output logic start_pulse,
    output logic busy,
    output logic fail
);

    logic done_accept;

    assign start_accept = start_req && !busy;
    assign done_accept  = ctl_done && busy;

    // Busy is set by an accepted start and cleared by an accepted completion.
    always_ff @(posedge clk) begin
        if (!rst_n)            busy <= 1'b0;
        else if (start_accept) busy <= 1'b1;
        else if (done_accept)  busy <= 1'b0;
    end

    // Fail is cleared by a new start and captured at completion.
    always_ff @(posedge clk) begin
        if (!rst_n)            fail <= 1'b0;
        else if (start_accept) fail <= 1'b0;
        else if (done_accept)  fail <= ctl_fail;
    end

    // Start pulse: high for the single cycle after an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) start_pulse <= 1'b0;
        else        start_pulse <= start_accept;
    end

    p_pulse_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |-> busy);

    p_pulse_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |=> !start_pulse);

    p_busy_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (start_req && busy) |=> !start_pulse);

    p_fail_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_accept && !done_accept) |=> $stable(fail));

    p_done_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_accept |=> !busy);

endmodule

// File: rtl/nvcmd_seq.sv
// Module: nvcmd_seq (top)
// Byte-wide command register loader. Ties the decoder, the arming state,
// the holding registers and the transfer handshake together, and forms
// the status readback word.
// Assumes the host writes one 32-bit word per strobe, with byte enables.
module nvcmd_seq
    import nvcmd_pkg::*;
#(
    parameter int REG_W    = 32,
    parameter int BYTE_W   = 8,
    parameter int ADDR_W   = 11,
    parameter int CMD_MSB  = 31,
    parameter int DATA_LSB = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [REG_W-1:0]        wr_data,
    input  logic [REG_W/BYTE_W-1:0] byte_en,
    input  logic                    ctl_done,
    input  logic                    ctl_fail,
    output logic [REG_W-1:0]        rd_data,
    output logic                    busy,
    output logic                    start_pulse,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic [BYTE_W-1:0]       mem_wdata
);

    localparam int BUSY_BIT = CMD_MSB;
    localparam int FAIL_BIT = CMD_MSB - CMD_W;
    localparam int ARM_LSB  = DATA_LSB + BYTE_W;
    localparam int HI_W     = ADDR_W - BYTE_W;

    cmd_ev_t           ev;
    logic              data_valid;
    logic [BYTE_W-1:0] data_byte;
    logic [ARM_N-1:0]  arm;
    logic              start_accept;
    logic              fail;
    logic [BYTE_W-1:0] armed_val;

    nvcmd_decode #(
        .REG_W   (REG_W),
        .BYTE_W  (BYTE_W),
        .CMD_MSB (CMD_MSB),
        .DATA_LSB(DATA_LSB)
    ) u_decode (
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .byte_en   (byte_en),
        .ev        (ev),
        .data_valid(data_valid),
        .data_byte (data_byte)
    );

    nvcmd_arm u_arm (
        .clk         (clk),
        .rst_n       (rst_n),
        .ev          (ev),
        .start_accept(start_accept),
        .arm         (arm)
    );

    nvcmd_hold #(
        .ADDR_W(ADDR_W),
        .BYTE_W(BYTE_W)
    ) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .data_valid(data_valid),
        .data_byte (data_byte),
        .arm       (arm),
        .addr      (mem_addr),
        .wdata     (mem_wdata)
    );

    nvcmd_xfer u_xfer (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_req   (ev.start_req),
        .ctl_done    (ctl_done),
        .ctl_fail    (ctl_fail),
        .start_accept(start_accept),
        .start_pulse (start_pulse),
        .busy        (busy),
        .fail        (fail)
    );

    // Select the contents of the currently armed register for readback.
    always_comb begin
        armed_val = '0;
        if (arm[ARM_LOW])  armed_val = mem_addr[BYTE_W-1:0];
        if (arm[ARM_HIGH]) armed_val = BYTE_W'(mem_addr[ADDR_W-1 -: HI_W]);
        if (arm[ARM_WD])   armed_val = mem_wdata;
    end

    // Assemble the status word; unassigned bits read zero.
    always_comb begin
        rd_data                        = '0;
        rd_data[BUSY_BIT]              = busy;
        rd_data[FAIL_BIT]              = fail;
        rd_data[ARM_LSB +: ARM_N]      = arm;
        rd_data[DATA_LSB +: BYTE_W]    = armed_val;
        rd_data[ADDR_W-1:0]            = mem_addr;
    end

    p_status_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> start_pulse);

    p_disarmed_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (arm == '0) |-> (rd_data[DATA_LSB +: BYTE_W] == '0));

endmodule

// File: tb/tb_nvcmd_seq.sv
module tb_nvcmd_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [3:0]  byte_en = '0;
    logic        ctl_done = 1'b0;
    logic        ctl_fail = 1'b0;
    logic [31:0] rd_data;
    logic        busy;
    logic        start_pulse;
    logic [10:0] mem_addr;
    logic [7:0]  mem_wdata;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;

    // behavioural model state
    int m_arm = 0;            // 0 none, 1 low, 2 high, 3 wdata
    int m_lo = 0, m_hi = 0, m_wd = 0;
    bit m_busy = 0, m_fail = 0, m_start = 0;
    bit model_on = 0;

    always #10 clk = ~clk;   // 50 MHz

    nvcmd_seq dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .byte_en(byte_en), .ctl_done(ctl_done), .ctl_fail(ctl_fail),
        .rd_data(rd_data), .busy(busy), .start_pulse(start_pulse),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] model_word();
        logic [31:0] w = '0;
        int sel = 0;
        w[31] = m_busy;
        w[28] = m_fail;
        if (m_arm == 1) begin w[24] = 1'b1; sel = m_lo; end
        if (m_arm == 2) begin w[25] = 1'b1; sel = m_hi; end
        if (m_arm == 3) begin w[26] = 1'b1; sel = m_wd; end
        w[23:16] = 8'(sel);
        w[10:0]  = 11'((m_hi << 8) | m_lo);
        return w;
    endfunction

    // reference model: advance on each clock edge from the inputs held there
    always @(posedge clk) begin
        bit old_busy;
        old_busy = m_busy;
        m_start = 0;
        if (!rst_n) begin
            m_arm = 0; m_lo = 0; m_hi = 0; m_wd = 0;
            m_busy = 0; m_fail = 0;
        end else begin
            if (wr_en && byte_en[2]) begin
                if (m_arm == 1) m_lo = int'(wr_data[23:16]);
                if (m_arm == 2) m_hi = int'(wr_data[18:16]);
                if (m_arm == 3) m_wd = int'(wr_data[23:16]);
            end
            if (wr_en && byte_en[3]) begin
                case (wr_data[31:29])
                    3'b100: m_arm = 1;
                    3'b101: m_arm = 2;
                    3'b000: m_arm = 3;
                    3'b110: if (!old_busy) begin
                        m_arm = 0; m_busy = 1; m_fail = 0; m_start = 1;
                    end
                    default: ;
                endcase
            end
            if (old_busy && ctl_done) begin
                m_busy = 0;
                m_fail = ctl_fail;
            end
        end
    end

    // compare every output with the model between clock edges
    always @(negedge clk) begin
        if (model_on && rst_n) begin
            check("R11 rd_data", rd_data, model_word());
            check("R7 start_pulse", 32'(start_pulse), 32'(m_start));
            check("R10 busy", 32'(busy), 32'(m_busy));
            check("R2/R3 mem_addr", 32'(mem_addr), 32'((m_hi << 8) | m_lo));
            check("R4 mem_wdata", 32'(mem_wdata), 32'(m_wd));
        end
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected<=50000", cycles);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    task automatic host_wr(input logic [31:0] d, input logic [3:0] be);
        @(posedge clk); #5;
        wr_en = 1'b1; wr_data = d; byte_en = be;
        @(posedge clk); #5;
        wr_en = 1'b0; byte_en = '0; wr_data = '0;
    endtask

    task automatic cmd(input logic [2:0] c);
        host_wr({c, 29'b0}, 4'b1000);
    endtask

    task automatic dat(input logic [7:0] b);
        host_wr({8'h00, b, 16'h0000}, 4'b0100);
    endtask

    task automatic finish_xfer(input logic f);
        @(posedge clk); #5;
        ctl_done = 1'b1; ctl_fail = f;
        @(posedge clk); #5;
        ctl_done = 1'b0; ctl_fail = 1'b0;
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    logic [31:0] snap;
    logic [31:0] lfsr = 32'h1ACE_B00C;

    initial begin
        repeat (3) @(posedge clk);
        #5 rst_n = 1'b1;
        model_on = 1;
        settle();
        // R1 reset state
        check("R1 rd_data after reset", rd_data, 32'h0);
        check("R1 start after reset", 32'(start_pulse), 32'h0);
        check("R1 wdata after reset", 32'(mem_wdata), 32'h0);

        // R6 data write with nothing armed
        dat(8'h3C); settle();
        check("R6 unarmed data ignored", rd_data, 32'h0);

        // R2 low address, R6 sticky overwrite
        cmd(3'b100); dat(8'hA5); settle();
        check("R2 low byte", 32'(mem_addr), 32'h0A5);
        dat(8'h5A); settle();
        check("R6 sticky overwrite", 32'(mem_addr), 32'h05A);

        // R5 switch arming, R3 high bits truncated
        cmd(3'b101); settle();
        check("R5 arm high one-hot", 32'(rd_data[26:24]), 32'h2);
        dat(8'hFF); settle();
        check("R3 high keeps 3 bits", 32'(mem_addr), 32'h75A);

        // R4 write data
        cmd(3'b000); dat(8'h77); settle();
        check("R4 wdata loaded", 32'(mem_wdata), 32'h77);
        check("R5 arm wdata one-hot", 32'(rd_data[26:24]), 32'h4);

        // R9 unassigned codes
        snap = rd_data;
        cmd(3'b001); cmd(3'b010); cmd(3'b011); cmd(3'b111); settle();
        check("R9 unassigned codes ignored", rd_data, snap);
        dat(8'h88); settle();
        check("R9 arming kept", 32'(mem_wdata), 32'h88);

        // R13 lane enables
        snap = rd_data;
        host_wr({3'b100, 5'b0, 8'h99, 16'hFFFF}, 4'b0011); settle();
        check("R13 other lanes ignored", rd_data, snap);
        host_wr({3'b100, 5'b0, 8'h42, 16'h0}, 4'b0100); settle();
        check("R13 data lane only", 32'(rd_data[26:16]), 32'h442);

        // R12 both lanes in one write
        host_wr({3'b100, 5'b0, 8'h11, 16'h0}, 4'b1100); settle();
        check("R12 data to old arm", 32'(mem_wdata), 32'h11);
        check("R12 command then applies", 32'(rd_data[26:24]), 32'h1);

        // R7 accepted start
        cmd(3'b110); settle();
        check("R7 start pulse", 32'(start_pulse), 32'h1);
        check("R7 busy set and disarmed", rd_data[31:24], 8'h80);
        settle();
        check("R7 single pulse", 32'(start_pulse), 32'h0);

        // R8 start while busy
        cmd(3'b100); cmd(3'b110); settle();
        check("R8 no pulse while busy", 32'(start_pulse), 32'h0);
        check("R8 arming kept", 32'(rd_data[26:24]), 32'h1);

        // R10 completion with failure, then clear on new start
        finish_xfer(1'b1); settle();
        check("R10 busy cleared fail set", rd_data[31:28], 4'h1);
        finish_xfer(1'b0); settle();
        check("R10 done while idle ignored", 32'(rd_data[28]), 32'h1);
        cmd(3'b110); settle();
        check("R7 fail cleared by start", rd_data[31:28], 4'h8);
        finish_xfer(1'b0); settle();
        check("R10 clean completion", rd_data[31:28], 4'h0);

        // mixed traffic against the model (R5, R6, R8, R10 interleavings)
        for (int i = 0; i < 600; i++) begin
            @(posedge clk); #5;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            wr_en    = lfsr[0];
            byte_en  = lfsr[4:1];
            wr_data  = {lfsr[31:29], lfsr[12:8], lfsr[20:13], lfsr[15:0]};
            ctl_done = (lfsr[7:5] == 3'b101);
            ctl_fail = lfsr[22];
        end
        @(posedge clk); #5;
        wr_en = 1'b0; byte_en = '0; ctl_done = 1'b0;
        repeat (3) @(posedge clk);
        settle();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule